// File: doc/BRIEF.md
# Indexed Effective Address Generator

This unit computes the operand address for the indexed family of addressing modes of a 16-bit processor core. For each request the decoder supplies the base register choice, the addressing mode, a constant offset, an accumulator choice and a step for the self-modifying modes, along with the current contents of the X, Y, SP and PC index registers and the A, B and D accumulators. One clock later the unit returns the effective address. For the auto-modify modes it also returns the updated value of the base register, to be written back.

The two indirect modes use a second stage. The unit first issues a one-cycle fetch request that carries the address of a memory word. It then waits, busy, until the memory side returns that word with a valid strobe. The returned word becomes the effective address. All address arithmetic wraps modulo 2^16.

A self-modifying mode that names PC as its base is not a legal combination. The unit answers it with a one-cycle error pulse and produces no address.

Top module: `idx_ea_gen`

## Requirements
- R1: After reset, ea_valid, ind_req, wb_valid, req_err and busy are all low.
- R2: Mode 0 (short constant) sign-extends offset[4:0] and adds it to the base register. The result is valid one cycle after the request. Base encoding: 0 selects X, 1 selects Y, 2 selects SP, 3 selects PC.
- R3: Mode 1 (medium constant) sign-extends offset[8:0] and adds it to the base register.
- R4: Mode 2 (full constant) adds all 16 bits of the offset to the base register. The sum wraps modulo 2^16.
- R5: Mode 3 (accumulator offset) adds an accumulator to the base register. acc_sel 0 selects A and acc_sel 1 selects B, both zero-extended. acc_sel 2 or 3 selects D.
- R6: Mode 4 (pre-modify) returns base+step as the address. In the same cycle it raises wb_valid, with wb_sel equal to base_sel and wb_value equal to base+step.
- R7: Mode 5 (post-modify) returns the unmodified base as the address. It raises wb_valid, with wb_value equal to base+step.
- R8: The step is formed as step_mag+1 (1 to 8). It is negated when step_dn is 1, which gives -8 to -1.
- R9: A request in mode 4 or 5 with base PC gives a one-cycle req_err pulse and no ea_valid, no wb_valid and no ind_req.
- R10: Mode 6 (indirect, full constant) and mode 7 (indirect, D offset) give a one-cycle ind_req pulse. ind_addr carries base+offset or base+D, and busy rises in the same cycle.
- R11: While busy, a ptr_valid sample makes the next cycle show ea_valid high with ea equal to ptr_data, and busy low.
- R12: req_valid is ignored while busy, and ptr_valid is ignored while not busy. In both cases no output pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| mode | input | 3 | Addressing mode code |
| base_sel | input | 2 | Base register choice |
| offset | input | 16 | Constant offset (low bits used per mode) |
| acc_sel | input | 2 | Accumulator choice for modes 3 |
| step_dn | input | 1 | Step direction, 1 = decrement |
| step_mag | input | 3 | Step magnitude minus one |
| reg_x | input | 16 | X register contents |
| reg_y | input | 16 | Y register contents |
| reg_sp | input | 16 | SP register contents |
| reg_pc | input | 16 | PC register contents |
| reg_a | input | 8 | Accumulator A |
| reg_b | input | 8 | Accumulator B |
| reg_d | input | 16 | Accumulator D |
| ptr_valid | input | 1 | Pointer word returned |
| ptr_data | input | 16 | Pointer word |
| ea_valid | output | 1 | Effective address valid pulse |
| ea | output | 16 | Effective address |
| ind_req | output | 1 | Pointer fetch request pulse |
| ind_addr | output | 16 | Address of the pointer word |
| wb_valid | output | 1 | Base register write-back pulse |
| wb_sel | output | 2 | Register to write back |
| wb_value | output | 16 | Updated base register value |
| req_err | output | 1 | Illegal combination pulse |
| busy | output | 1 | Waiting for pointer word |

## Verification
A wrong offset extension or a wrong base selection shows up as a wrong ea in the cycle after the request, so each sweep entry exposes it at once. A busy flag that gets stuck or is lost shows in the same cycle as a dropped or an extra ea_valid pulse. It shows either on the ignored request that the bench issues in the middle of a pointer wait, or on the stray ptr_valid it drives while the unit is idle. A swapped pre/post choice shows as ea differing from wb_value when the two should match, or matching when they should differ.

// File: rtl/idx_ea_pkg.sv
`timescale 1ns/1ps
package idx_ea_pkg;
  typedef enum logic [2:0] {
    AM_K5     = 3'd0,
    AM_K9     = 3'd1,
    AM_K16    = 3'd2,
    AM_ACC    = 3'd3,
    AM_PRE    = 3'd4,
    AM_POST   = 3'd5,
    AM_IND_K  = 3'd6,
    AM_IND_D  = 3'd7
  } am_e;

  typedef enum logic [1:0] {
    BR_X  = 2'd0,
    BR_Y  = 2'd1,
    BR_SP = 2'd2,
    BR_PC = 2'd3
  } br_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } st_e;
endpackage

// File: rtl/idx_base_mux.sv
`timescale 1ns/1ps
module idx_base_mux
  import idx_ea_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [1:0]    sel,
  input  logic [AW-1:0] x,
  input  logic [AW-1:0] y,
  input  logic [AW-1:0] sp,
  input  logic [AW-1:0] pc,
  output logic [AW-1:0] base
);
  always_comb begin
    unique case (br_e'(sel))
      BR_X:    base = x;
      BR_Y:    base = y;
      BR_SP:   base = sp;
      default: base = pc;
    endcase
  end
endmodule

// File: rtl/idx_offset_gen.sv
`timescale 1ns/1ps
module idx_offset_gen
  import idx_ea_pkg::*;
#(
  parameter int AW   = 16,
  parameter int ACCW = 8,
  parameter int SW   = 3,
  parameter int K5W  = 5,
  parameter int K9W  = 9
) (
  input  logic [2:0]      mode,
  input  logic [AW-1:0]   offset,
  input  logic [1:0]      acc_sel,
  input  logic [ACCW-1:0] a,
  input  logic [ACCW-1:0] b,
  input  logic [AW-1:0]   d,
  input  logic            step_dn,
  input  logic [SW-1:0]   step_mag,
  output logic [AW-1:0]   off_val,
  output logic            is_mod,
  output logic            is_post,
  output logic            is_ind
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] k5_ext, k9_ext, acc_ext, mag_ext, delta;

  assign k5_ext  = {{(AW-K5W){offset[K5W-1]}}, offset[K5W-1:0]};
  assign k9_ext  = {{(AW-K9W){offset[K9W-1]}}, offset[K9W-1:0]};
  assign mag_ext = {{(AW-SW){1'b0}}, step_mag} + ONE;
  assign delta   = step_dn ? (~mag_ext + ONE) : mag_ext;

  always_comb begin
    unique case (acc_sel)
      2'd0:    acc_ext = {{(AW-ACCW){1'b0}}, a};
      2'd1:    acc_ext = {{(AW-ACCW){1'b0}}, b};
      default: acc_ext = d;
    endcase
  end

  always_comb begin
    is_mod  = 1'b0;
    is_post = 1'b0;
    is_ind  = 1'b0;
    unique case (am_e'(mode))
      AM_K5:    off_val = k5_ext;
      AM_K9:    off_val = k9_ext;
      AM_K16:   off_val = offset;
      AM_ACC:   off_val = acc_ext;
      AM_PRE:   begin off_val = delta; is_mod = 1'b1; end
      AM_POST:  begin off_val = delta; is_mod = 1'b1; is_post = 1'b1; end
      AM_IND_K: begin off_val = offset; is_ind = 1'b1; end
      default:  begin off_val = d; is_ind = 1'b1; end
    endcase
  end

  always_comb begin
    if (is_mod) begin
      AST_STEP_NONZERO: assert (delta != '0); // R8
    end
  end
endmodule

// File: rtl/idx_ea_gen.sv
`timescale 1ns/1ps
module idx_ea_gen
  import idx_ea_pkg::*;
#(
  parameter int AW   = 16,
  parameter int ACCW = 8,
  parameter int SW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [2:0]      mode,
  input  logic [1:0]      base_sel,
  input  logic [AW-1:0]   offset,
  input  logic [1:0]      acc_sel,
  input  logic            step_dn,
  input  logic [SW-1:0]   step_mag,
  input  logic [AW-1:0]   reg_x,
  input  logic [AW-1:0]   reg_y,
  input  logic [AW-1:0]   reg_sp,
  input  logic [AW-1:0]   reg_pc,
  input  logic [ACCW-1:0] reg_a,
  input  logic [ACCW-1:0] reg_b,
  input  logic [AW-1:0]   reg_d,
  input  logic            ptr_valid,
  input  logic [AW-1:0]   ptr_data,
  output logic            ea_valid,
  output logic [AW-1:0]   ea,
  output logic            ind_req,
  output logic [AW-1:0]   ind_addr,
  output logic            wb_valid,
  output logic [1:0]      wb_sel,
  output logic [AW-1:0]   wb_value,
  output logic            req_err,
  output logic            busy
);
  logic [AW-1:0] base, off_val, sum, ea_next;
  logic          is_mod, is_post, is_ind, pc_mod;
  st_e           state;

  idx_base_mux #(.AW(AW)) u_base (
    .sel (base_sel),
    .x   (reg_x),
    .y   (reg_y),
    .sp  (reg_sp),
    .pc  (reg_pc),
    .base(base)
  );

  idx_offset_gen #(.AW(AW), .ACCW(ACCW), .SW(SW)) u_off (
    .mode    (mode),
    .offset  (offset),
    .acc_sel (acc_sel),
    .a       (reg_a),
    .b       (reg_b),
    .d       (reg_d),
    .step_dn (step_dn),
    .step_mag(step_mag),
    .off_val (off_val),
    .is_mod  (is_mod),
    .is_post (is_post),
    .is_ind  (is_ind)
  );

  assign sum     = base + off_val;
  assign ea_next = is_post ? base : sum;
  assign pc_mod  = is_mod && (br_e'(base_sel) == BR_PC);
  assign busy    = (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ea_valid <= 1'b0;
      ea       <= '0;
      ind_req  <= 1'b0;
      ind_addr <= '0;
      wb_valid <= 1'b0;
      wb_sel   <= '0;
      wb_value <= '0;
      req_err  <= 1'b0;
    end else begin
      ea_valid <= 1'b0;
      ind_req  <= 1'b0;
      wb_valid <= 1'b0;
      req_err  <= 1'b0;
      if (state == ST_WAIT) begin
        if (ptr_valid) begin
          ea       <= ptr_data;
          ea_valid <= 1'b1;
          state    <= ST_IDLE;
        end
      end else if (req_valid) begin
        if (pc_mod) begin
          req_err <= 1'b1;
        end else if (is_ind) begin
          ind_req  <= 1'b1;
          ind_addr <= sum;
          state    <= ST_WAIT;
        end else begin
          ea       <= ea_next;
          ea_valid <= 1'b1;
          if (is_mod) begin
            wb_valid <= 1'b1;
            wb_sel   <= base_sel;
            wb_value <= sum;
          end
        end
      end
    end
  end

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ea_valid, ind_req, req_err})); // R9
  AST_IND_PULSE: assert property (@(posedge clk) disable iff (rst)
    ind_req |=> !ind_req); // R10
  AST_IND_BUSY: assert property (@(posedge clk) disable iff (rst)
    ind_req |-> busy); // R10
  AST_WB_WITH_EA: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> ea_valid); // R6
  AST_NO_PC_WB: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (wb_sel != 2'd3)); // R9
  AST_PTR_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (busy && ptr_valid) |=> (ea_valid && !busy && ea == $past(ptr_data))); // R11
  AST_IDLE_REQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (busy && !ptr_valid) |=> !ea_valid && !ind_req && !req_err); // R12
endmodule

// File: tb/test_idx_ea_gen.sv
`timescale 1ns/1ps
module test_idx_ea_gen;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, step_dn, ptr_valid;
  logic [2:0]  mode, step_mag;
  logic [1:0]  base_sel, acc_sel;
  logic [15:0] offset, reg_x, reg_y, reg_sp, reg_pc, reg_d, ptr_data;
  logic [7:0]  reg_a, reg_b;
  logic        ea_valid, ind_req, wb_valid, req_err, busy;
  logic [15:0] ea, ind_addr, wb_value;
  logic [1:0]  wb_sel;
  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  idx_ea_gen i_idx_ea_gen (
    .clk(clk), .rst(rst), .req_valid(req_valid), .mode(mode), .base_sel(base_sel),
    .offset(offset), .acc_sel(acc_sel), .step_dn(step_dn), .step_mag(step_mag),
    .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp), .reg_pc(reg_pc),
    .reg_a(reg_a), .reg_b(reg_b), .reg_d(reg_d),
    .ptr_valid(ptr_valid), .ptr_data(ptr_data),
    .ea_valid(ea_valid), .ea(ea), .ind_req(ind_req), .ind_addr(ind_addr),
    .wb_valid(wb_valid), .wb_sel(wb_sel), .wb_value(wb_value),
    .req_err(req_err), .busy(busy)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s mode=%0d base=%0d actual=%h expected=%h", tag, mode, base_sel, act, exp);
    end
  endtask

  function automatic logic [15:0] base_of(input logic [1:0] s);
    case (s)
      2'd0: base_of = reg_x;
      2'd1: base_of = reg_y;
      2'd2: base_of = reg_sp;
      default: base_of = reg_pc;
    endcase
  endfunction

  function automatic logic [15:0] step_of();
    logic [15:0] m;
    m = 16'(step_mag) + 16'd1;
    step_of = step_dn ? 16'(16'd0 - m) : m;
  endfunction

  function automatic string tag_of(input int m);
    case (m)
      0: tag_of = "R2";
      1: tag_of = "R3";
      2: tag_of = "R4";
      3: tag_of = "R5";
      4: tag_of = "R6 R8";
      5: tag_of = "R7 R8";
      default: tag_of = "R10";
    endcase
  endfunction

  task automatic run_one(input int m, input int bs);
    logic [15:0] b, exp_ea, exp_wb, accv;
    string t;
    @(negedge clk);
    reg_x = 16'($urandom); reg_y = 16'($urandom); reg_sp = 16'($urandom);
    reg_pc = 16'($urandom); reg_a = 8'($urandom); reg_b = 8'($urandom);
    reg_d = 16'($urandom); offset = 16'($urandom);
    acc_sel = 2'($urandom); step_dn = 1'($urandom); step_mag = 3'($urandom);
    mode = 3'(m); base_sel = 2'(bs); req_valid = 1'b1;
    b = base_of(base_sel);
    accv = (acc_sel == 2'd0) ? {8'd0, reg_a} : (acc_sel == 2'd1) ? {8'd0, reg_b} : reg_d;
    exp_wb = 16'(b + step_of());
    case (m)
      0: exp_ea = 16'(b + {{11{offset[4]}}, offset[4:0]});
      1: exp_ea = 16'(b + {{7{offset[8]}}, offset[8:0]});
      2: exp_ea = 16'(b + offset);
      3: exp_ea = 16'(b + accv);
      4: exp_ea = exp_wb;
      5: exp_ea = b;
      6: exp_ea = 16'(b + offset);
      default: exp_ea = 16'(b + reg_d);
    endcase
    t = tag_of(m);
    @(negedge clk);
    req_valid = 1'b0;
    if ((m == 4 || m == 5) && bs == 3) begin
      chk("R9 err", {15'd0, req_err}, 16'd1);
      chk("R9 no ea", {13'd0, ea_valid, wb_valid, ind_req}, 16'd0);
    end else if (m >= 6) begin
      chk("R10 req", {14'd0, ind_req, busy}, 16'd3);
      chk(t, ind_addr, exp_ea);
      mode = 3'd2; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R12 busy req", {13'd0, ea_valid, ind_req, busy}, 16'd1);
      ptr_data = 16'($urandom); ptr_valid = 1'b1;
      @(negedge clk);
      ptr_valid = 1'b0;
      chk("R11 ea_valid", {14'd0, ea_valid, busy}, 16'd2);
      chk("R11 ea", ea, ptr_data);
    end else begin
      chk(t, {15'd0, ea_valid}, 16'd1);
      chk(t, ea, exp_ea);
      if (m == 4 || m == 5) begin
        chk(t, {14'd0, wb_sel}, 16'(bs));
        chk(t, {15'd0, wb_valid}, 16'd1);
        chk(t, wb_value, exp_wb);
      end else begin
        chk(t, {15'd0, wb_valid}, 16'd0);
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; ptr_valid = 1'b0; mode = '0; base_sel = '0;
    offset = '0; acc_sel = '0; step_dn = 1'b0; step_mag = '0;
    reg_x = '0; reg_y = '0; reg_sp = '0; reg_pc = '0; reg_a = '0; reg_b = '0;
    reg_d = '0; ptr_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset", {11'd0, ea_valid, ind_req, wb_valid, req_err, busy}, 16'd0);
    rst = 1'b0;
    // R4 explicit wrap: X=FFF0 + 0020 -> 0010
    @(negedge clk);
    reg_x = 16'hFFF0; offset = 16'h0020; mode = 3'd2; base_sel = 2'd0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R4 wrap", ea, 16'h0010);
    // R12 stray pointer while idle
    ptr_valid = 1'b1; ptr_data = 16'h1234;
    @(negedge clk);
    ptr_valid = 1'b0;
    chk("R12 idle ptr", {15'd0, ea_valid}, 16'd0);
    for (int rep = 0; rep < 12; rep++)
      for (int m = 0; m < 8; m++)
        for (int bs = 0; bs < 4; bs++)
          run_one(m, bs);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule